// File: doc/BRIEF.md
# Two-Channel Four-Mode Timer/Counter

This block holds two 16-bit count channels for a small controller. Each channel either counts machine cycles or counts falling edges seen on its own count pin. A run bit starts and stops each channel. A gate pin can also hold a channel, so software can time how long a pulse stays high. A one-cycle `mcStrobe` pulse marks each machine cycle. Counting happens only on clock edges where the strobe is high.

A 4-bit configuration nibble sets how each channel counts. It selects one of four modes:
- **Mode 0:** an 8-bit counter behind a 5-bit prescaler.
- **Mode 1:** a plain 16-bit counter.
- **Mode 2:** an 8-bit counter that reloads itself.
- **Mode 3:** a split mode. Channel 0 becomes two independent 8-bit counters and channel 1 stops.

When a channel wraps to zero it sets a sticky overflow flag. The flag drives an output pin and stays set until software clears it. Software reaches all configuration, control and count bytes through a simple write port and a combinational read port.

Top module: `tmr_unit`

## Requirements
- R1: Register map.
  - Address 0 holds the configuration byte: bits 3:0 for channel 0 and bits 7:4 for channel 1. In each nibble, bit 3 is gate enable, bit 2 selects the edge source (1) or the machine-cycle source (0), and bits 1:0 are the mode.
  - Address 1 holds the control byte: run bits at bits 1:0 and overflow flags at bits 5:4.
  - Addresses 2 and 3 are channel 0's low and high count bytes. Addresses 4 and 5 are channel 1's low and high count bytes.
  - Every written register reads back.
- R2: With the machine-cycle source selected, an enabled channel advances exactly once for each strobe.
- R3: A channel is enabled only when its run bit is 1 and either its gate enable is 0 or its gate pin is high.
- R4: With the edge source selected, the count pin is sampled on each strobe. A count happens on the strobe after the one whose sample was 0 when the previous sample was 1. A pin held low adds no further counts.
- R5: Mode 0 behaves as follows:
  - Bits 4:0 of the low byte act as a prescaler.
  - The high byte advances when the prescaler wraps from 31.
  - Low-byte bits 7:5 are left unchanged.
  - Overflow occurs when the high byte wraps from 0xFF.
- R6: Mode 1 counts the 16-bit pair {high, low} and overflows when it goes from 0xFFFF to 0x0000.
- R7: Mode 2 counts the low byte. On a step from 0xFF it loads the high byte into the low byte and overflows. The high byte is not changed.
- R8: Split mode, when channel 0 is set to mode 3:
  - Channel 0's low byte counts under channel 0's own controls and sets flag 0.
  - Channel 0's high byte counts every strobe while run bit 1 is set. It ignores the gate and sets flag 1.
  - Channel 1 holds its count whenever either channel is configured for mode 3.
- R9: An overflow flag is set by hardware and stays set. A control-byte write with 0 in the flag's bit clears it, and a 1 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R10: A write to a count byte in the same cycle as an increment leaves that byte holding the written value.
- R11: After reset, every register reads 0 and both overflow outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mcStrobe | input | 1 | One-cycle pulse per machine cycle |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data (combinational) |
| cntPin | input | 2 | External count pins, one per channel |
| gatePin | input | 2 | External gate pins, one per channel |
| ovf | output | 2 | Sticky overflow flags, one per channel |

## Verification
Two pairs of actions can land on the same clock edge.

The first pair is a software write to a count byte and a strobe that would increment that byte. The bench raises `wrEn` and `mcStrobe` together while channel 0 runs in mode 1. It expects the written value, and then the written value plus one after one more strobe.

The second pair is a software clear of a flag and a hardware wrap that sets the same flag. The bench preloads 0xFFFF and clears the flag on the wrapping strobe. It judges that the flag pin stays high.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W   = 8;
  localparam int NCH      = 2;
  localparam int CFG_W    = 4;
  localparam int ADDR_W   = 3;
  localparam int FLAG_LSB = 4;
  localparam int CNT_BASE = 2;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;

  localparam logic [1:0] MODE_PRE    = 2'd0;
  localparam logic [1:0] MODE_WIDE   = 2'd1;
  localparam logic [1:0] MODE_RELOAD = 2'd2;
  localparam logic [1:0] MODE_SPLIT  = 2'd3;

  // per-channel configuration nibble
  typedef struct packed {
    logic       gate;
    logic       ext;
    logic [1:0] mode;
  } chan_cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NCH-1:0] tick;
    logic           splitTick;
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  mcStrobe,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [NCH-1:0]        cntPin,
  input  logic [NCH-1:0]        gatePin,
  output chan_cfg_t [NCH-1:0]   cfg,
  output logic [NCH-1:0]        run,
  output tmr_strobe_t           stb
);
  logic [NCH-1:0] smpNow, smpOld, fall, allow, halt, tickV;
  logic splitT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg    <= '0;
      run    <= '0;
      smpNow <= '0;
      smpOld <= '0;
    end else begin
      if (wrEn && wrAddr == A_MODE) cfg <= wrData[NCH*CFG_W-1:0];
      if (wrEn && wrAddr == A_CTRL) run <= wrData[NCH-1:0];
      if (mcStrobe) begin
        smpNow <= cntPin;
        smpOld <= smpNow;
      end
    end
  end

  // channel 1 stops whenever either channel selects split mode
  assign halt[0] = 1'b0;
  assign halt[1] = (cfg[0].mode == MODE_SPLIT) || (cfg[1].mode == MODE_SPLIT);

  for (genvar c = 0; c < NCH; c++) begin : g_src
    assign fall[c]  = smpOld[c] & ~smpNow[c];
    assign allow[c] = run[c] & (~cfg[c].gate | gatePin[c]);
    assign tickV[c] = mcStrobe & allow[c] & ~halt[c] & (cfg[c].ext ? fall[c] : 1'b1);
  end

  // second split counter: channel 1 run bit, machine cycles, no gate
  assign splitT = mcStrobe & run[1] & (cfg[0].mode == MODE_SPLIT);
  assign stb    = {tickV, splitT};
endmodule

// File: rtl/tmr_data.sv
module tmr_data
  import tmr_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [BYTE_W-1:0]             wrData,
  input  chan_cfg_t [NCH-1:0]           cfg,
  input  tmr_strobe_t                   stb,
  output logic [NCH-1:0][BYTE_W-1:0]    lo,
  output logic [NCH-1:0][BYTE_W-1:0]    hi,
  output logic [NCH-1:0]                flag
);
  logic [NCH-1:0] wrapV, wrapHiV, setV;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [BYTE_W-1:0] loQ, hiQ, nLo, nHi;
    logic wrapLo, wrapHi, splitHere;

    assign splitHere = (c == 0) ? stb.splitTick : 1'b0;

    always_comb begin
      nLo    = loQ;
      nHi    = hiQ;
      wrapLo = 1'b0;
      wrapHi = 1'b0;
      if (stb.tick[c]) begin
        case (cfg[c].mode)
          MODE_PRE: begin
            nLo[PRE_W-1:0] = loQ[PRE_W-1:0] + PRE_W'(1);
            if (&loQ[PRE_W-1:0]) begin
              nHi    = hiQ + BYTE_W'(1);
              wrapLo = &hiQ;
            end
          end
          MODE_WIDE: begin
            {nHi, nLo} = {hiQ, loQ} + (2*BYTE_W)'(1);
            wrapLo     = &{hiQ, loQ};
          end
          MODE_RELOAD: begin
            if (&loQ) begin
              nLo    = hiQ;
              wrapLo = 1'b1;
            end else begin
              nLo = loQ + BYTE_W'(1);
            end
          end
          default: begin
            nLo    = loQ + BYTE_W'(1);
            wrapLo = &loQ;
          end
        endcase
      end
      if (splitHere) begin
        nHi    = hiQ + BYTE_W'(1);
        wrapHi = &hiQ;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loQ <= '0;
        hiQ <= '0;
      end else begin
        loQ <= nLo;
        hiQ <= nHi;
        if (wrEn && wrAddr == ADDR_W'(CNT_BASE + 2*c))     loQ <= wrData;
        if (wrEn && wrAddr == ADDR_W'(CNT_BASE + 2*c + 1)) hiQ <= wrData;
      end
    end

    assign lo[c]      = loQ;
    assign hi[c]      = hiQ;
    assign wrapV[c]   = wrapLo;
    assign wrapHiV[c] = wrapHi;
  end

  always_comb begin
    setV    = wrapV;
    setV[1] = wrapV[1] | wrapHiV[0];
  end

  // hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) flag <= '0;
    else if (wrEn && wrAddr == A_CTRL) flag <= (flag & wrData[FLAG_LSB +: NCH]) | setV;
    else flag <= flag | setV;
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcStrobe,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic [2:0]        rdAddr,
  output logic [7:0]        rdData,
  input  logic [1:0]        cntPin,
  input  logic [1:0]        gatePin,
  output logic [1:0]        ovf
);
  chan_cfg_t [NCH-1:0]          cfg;
  logic [NCH-1:0]               run;
  tmr_strobe_t                  stb;
  logic [NCH-1:0][BYTE_W-1:0]   lo, hi;
  logic [NCH-1:0]               flag;
  logic [2*BYTE_W-1:0]          cnt0View, cnt1View;

  tmr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .cntPin(cntPin), .gatePin(gatePin),
    .cfg(cfg), .run(run), .stb(stb)
  );

  tmr_data #(.PRE_W(PRE_W)) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfg(cfg), .stb(stb), .lo(lo), .hi(hi), .flag(flag)
  );

  assign ovf      = flag;
  assign cnt0View = {hi[0], lo[0]};
  assign cnt1View = {hi[1], lo[1]};

  always_comb begin
    rdData = '0;
    if (rdAddr == A_MODE) rdData = cfg;
    else if (rdAddr == A_CTRL) begin
      rdData[NCH-1:0]          = run;
      rdData[FLAG_LSB +: NCH]  = flag;
    end
    for (int c = 0; c < NCH; c++) begin
      if (rdAddr == ADDR_W'(CNT_BASE + 2*c))     rdData = lo[c];
      if (rdAddr == ADDR_W'(CNT_BASE + 2*c + 1)) rdData = hi[c];
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mcStrobe,
  input logic        wrEn,
  input logic [7:0]  cfgBits,
  input logic [1:0]  runBits,
  input logic [1:0]  flagBits,
  input logic [15:0] cnt0,
  input logic [15:0] cnt1
);
  // R2: counts move only on a strobe or a write
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!mcStrobe && !wrEn) |=> ($stable(cnt0) && $stable(cnt1)));

  // R3: channel 0 low byte frozen while its run bit is clear
  p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!runBits[0] && !wrEn) |=> $stable(cnt0[7:0]));

  // R6: ungated 16-bit timer steps by one per strobe
  p_wide_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBits[3:0] == 4'b0001 && runBits[0] && mcStrobe && !wrEn)
      |=> (cnt0 == $past(cnt0) + 16'd1));

  // R8: channel 1 held while channel 0 is split
  p_split_halt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBits[1:0] == 2'b11 && !wrEn) |=> $stable(cnt1));

  // R9: flags rise only after a strobe and stay up without a write
  p_flag0_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagBits[0]) |-> $past(mcStrobe));
  p_flag1_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagBits[1]) |-> $past(mcStrobe));
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flagBits[0] && !wrEn) |=> flagBits[0]);
endmodule

bind tmr_unit tmr_chk u_chk (
  .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .wrEn(wrEn),
  .cfgBits(cfg), .runBits(run), .flagBits(flag),
  .cnt0(cnt0View), .cnt1(cnt1View)
);

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mcStrobe = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [1:0] cntPin = 2'b11;
  logic [1:0] gatePin = 2'b00;
  logic [1:0] ovf;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_unit u0 (
    .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .cntPin(cntPin), .gatePin(gatePin), .ovf(ovf)
  );

  typedef struct packed {
    logic [3:0] modeNib;
    logic       gp;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] n;
    logic [7:0] eHi;
    logic [7:0] eLo;
    logic       eOvf;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{4'h1, 1'b0, 8'h00, 8'h00, 8'd5, 8'h00, 8'h05, 1'b0},
    '{4'h1, 1'b0, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 1'b1},
    '{4'h0, 1'b0, 8'h10, 8'h1E, 8'd3, 8'h11, 8'h01, 1'b0},
    '{4'h0, 1'b0, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'hE0, 1'b1},
    '{4'h2, 1'b0, 8'hF0, 8'hFE, 8'd4, 8'hF0, 8'hF2, 1'b1},
    '{4'h2, 1'b0, 8'h80, 8'h10, 8'd3, 8'h80, 8'h13, 1'b0},
    '{4'h3, 1'b0, 8'h00, 8'hFF, 8'd2, 8'h00, 8'h01, 1'b1},
    '{4'h9, 1'b0, 8'h01, 8'h00, 8'd4, 8'h01, 8'h00, 1'b0},
    '{4'h9, 1'b1, 8'h01, 8'h00, 8'd4, 8'h01, 8'h04, 1'b0}
  };

  function automatic string tagOf(input logic [3:0] m);
    case (m)
      4'h0: return "R5";
      4'h1: return "R2/R6";
      4'h2: return "R7";
      4'h3: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic mc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mcStrobe = 1'b1;
      @(negedge clk); mcStrobe = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, h;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R11 reg", {8'h00, d}, 16'h0000);
    end
    chk("R11 ovf", {14'h0, ovf}, 16'h0);

    // R1 readback
    wr(3'd0, 8'hA5); rd(3'd0, d); chk("R1 cfg", {8'h0, d}, 16'h00A5);
    wr(3'd1, 8'h03); rd(3'd1, d); chk("R1 ctrl", {8'h0, d}, 16'h0003);
    wr(3'd1, 8'h00);

    // table walk on channel 0
    for (int i = 0; i < 9; i++) begin
      wr(3'd1, 8'h00);
      wr(3'd0, {4'h0, VECS[i].modeNib});
      gatePin[0] = VECS[i].gp;
      wr(3'd2, VECS[i].lo);
      wr(3'd3, VECS[i].hi);
      wr(3'd1, 8'h01);
      mc(int'(VECS[i].n));
      wr(3'd1, 8'h30);
      rd(3'd2, d); rd(3'd3, h);
      chk(tagOf(VECS[i].modeNib), {h, d}, {VECS[i].eHi, VECS[i].eLo});
      chk("R9 table flag", {15'h0, ovf[0]}, {15'h0, VECS[i].eOvf});
    end
    gatePin = 2'b00;

    // R4 edge counting on channel 1, mode 1
    wr(3'd1, 8'h00); wr(3'd0, 8'h50); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd1, 8'h02);
    mc(2);
    cntPin[1] = 1'b0;
    mc(1); rd(3'd4, d); chk("R4 no count yet", {8'h0, d}, 16'h0000);
    mc(1); rd(3'd4, d); chk("R4 count after edge", {8'h0, d}, 16'h0001);
    mc(3); rd(3'd4, d); chk("R4 held low", {8'h0, d}, 16'h0001);
    cntPin[1] = 1'b1; mc(2); cntPin[1] = 1'b0; mc(2);
    rd(3'd4, d); chk("R4 second edge", {8'h0, d}, 16'h0002);
    cntPin[1] = 1'b1;

    // R8 split mode with gate set and pin low on channel 0
    wr(3'd1, 8'h00); wr(3'd0, 8'h1B);
    wr(3'd2, 8'h40); wr(3'd3, 8'hFE); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd1, 8'h02);
    mc(2);
    rd(3'd3, d); chk("R8 split high", {8'h0, d}, 16'h0000);
    rd(3'd2, d); chk("R8 split low held", {8'h0, d}, 16'h0040);
    rd(3'd4, d); chk("R8 ch1 halted", {8'h0, d}, 16'h0000);
    chk("R8 flags", {14'h0, ovf}, 16'h0002);
    wr(3'd1, 8'h00); wr(3'd0, 8'h30); wr(3'd1, 8'h02);
    mc(3);
    rd(3'd4, d); chk("R8 ch1 mode3 halted", {8'h0, d}, 16'h0000);

    // R10 write versus increment
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    @(negedge clk); mcStrobe = 1'b1; wrEn = 1'b1; wrAddr = 3'd2; wrData = 8'h55;
    @(negedge clk); mcStrobe = 1'b0; wrEn = 1'b0;
    rd(3'd2, d); chk("R10 write wins", {8'h0, d}, 16'h0055);
    mc(1); rd(3'd2, d); chk("R10 resume", {8'h0, d}, 16'h0056);

    // R9 sticky, clear, set wins
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    mc(1); chk("R9 set", {15'h0, ovf[0]}, 16'h1);
    mc(5); chk("R9 sticky", {15'h0, ovf[0]}, 16'h1);
    wr(3'd1, 8'h01); chk("R9 clear", {15'h0, ovf[0]}, 16'h0);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); mcStrobe = 1'b1; wrEn = 1'b1; wrAddr = 3'd1; wrData = 8'h01;
    @(negedge clk); mcStrobe = 1'b0; wrEn = 1'b0;
    chk("R9 set beats clear", {15'h0, ovf[0]}, 16'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule